// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table with Pending Replay

This block keeps a table of message-signalled interrupt vectors for one device function. Each vector owns a 16-byte entry made of a 64-bit message address, a 32-bit message data word and a 32-bit control word. Bit 0 of the control word masks the vector. When the device raises a request for an unmasked vector that is in use, the block issues one message write (address and data) on a valid/ready output. If the vector is masked, the block records the request in a pending-bit array instead. Once the vector is unmasked, the block replays that pending message by itself.

Host software accesses the table through a 32-bit word port that decodes a byte offset, and reads the pending array through a separate read-only port. A per-vector use counter, driven by the device side, controls which vectors accept requests. When the last user releases a vector, that vector's pending bit is discarded. A function-wide mask input covers every vector at once.

Top module: `msix_engine`

## Requirements
- R1: After reset every control word reads 1 (masked), every address and data word reads 0, the whole pending array reads 0, `msg_valid` is low and the use counts are zero.
- R2: A table word sits at byte offset `16*v + 4*f`, where f=0 is address bits 31:0, f=1 is address bits 63:32, f=2 is the data word and f=3 is the control word. A write followed by a read at the same offset returns the written value.
- R3: A table write is ignored when offset bits 1:0 are not zero or when `offset/16` is NUM_VEC or more. A read under either condition returns 0.
- R4: A request accepted for an unmasked, in-use vector raises `msg_valid` on the next cycle with that entry's address and data. Both stay stable while `msg_ready` is low, and `msg_valid` drops in the cycle after the handshake completes.
- R5: A vector is masked when its control bit 0 is set or `fn_mask` is high. A request for a masked, in-use vector sends nothing and sets that vector's pending bit.
- R6: A request whose index is NUM_VEC or more, or whose vector has a use count of zero, is dropped. It neither sends a message nor sets a pending bit.
- R7: A pending vector that becomes unmasked, through a control write or through `fn_mask` falling, has its pending bit cleared and its message sent. When several vectors are pending, the lowest index goes first.
- R8: `use_en` with `use_up=1` raises a vector's count (holding at its maximum), and with `use_up=0` lowers it. Lowering a count from 1 to 0 clears the vector's pending bit. Lowering a count that is already 0 has no effect.
- R9: Pending bit v sits at bit `v%32` of the 32-bit word at byte offset `4*(v/32)`. The array is padded to a multiple of 64 bits, the padding reads 0, and a read at an offset with bits 1:0 not zero returns 0.
- R10: `req_ready` is low while a message is outstanding, while a table write is presented and while any replay is waiting. A control write and a request for the same vector therefore resolve against the written mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fn_mask | input | 1 | Function-wide mask for all vectors |
| tbl_we | input | 1 | Table write strobe |
| tbl_waddr | input | OFF_W | Table write byte offset |
| tbl_wdata | input | 32 | Table write data |
| tbl_raddr | input | OFF_W | Table read byte offset |
| tbl_rdata | output | 32 | Table read data (combinational) |
| pba_raddr | input | PBA_OFF_W | Pending array read byte offset |
| pba_rdata | output | 32 | Pending array read data (combinational) |
| use_en | input | 1 | Use-count update strobe |
| use_up | input | 1 | 1 raises the count, 0 lowers it |
| use_vec | input | VEC_W | Vector index for the use update |
| req_valid | input | 1 | Device interrupt request |
| req_vec | input | VEC_W | Requested vector index |
| req_ready | output | 1 | Request accepted in this cycle |
| msg_valid | output | 1 | Message write outstanding |
| msg_ready | input | 1 | Message write accepted |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The assertions assume that the receiver of a message handshake will eventually raise `msg_ready`, and that a device request stays held until `req_ready` is seen high. The hold property also assumes the block itself never withdraws `msg_valid`. The bench drives every input on the falling edge and keeps `req_valid` asserted until the acceptance edge. It raises `msg_ready` only for single cycles that it picks, so that held messages and replay order can be seen at the ports.

// File: rtl/msix_pkg.sv
package msix_pkg;

  typedef enum logic [1:0] {
    FLD_ADDR_LO = 2'd0,
    FLD_ADDR_HI = 2'd1,
    FLD_DATA    = 2'd2,
    FLD_CTRL    = 2'd3
  } field_e;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
  } msg_t;

  // Word select inside a 16-byte entry.
  function automatic field_e field_of(input logic [3:0] entry_byte);
    return field_e'(entry_byte[3:2]);
  endfunction

  // Host ports take whole 32-bit words only.
  function automatic logic word_aligned(input logic [1:0] low_bits);
    return low_bits == 2'b00;
  endfunction

endpackage

// File: rtl/msix_table.sv
module msix_table
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int IDX_W   = 3,
  parameter int VEC_W   = 4,
  parameter int OFF_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [31:0]      wr_data,
  input  logic [OFF_W-1:0] rd_off,
  output logic [31:0]      rd_data,
  input  logic [IDX_W-1:0] fetch_idx,
  output msg_t             fetch_msg,
  output logic [NUM_VEC-1:0] vec_mask
);

  localparam logic [VEC_W-1:0] NV = VEC_W'(NUM_VEC);

  logic [31:0] addr_lo [NUM_VEC];
  logic [31:0] addr_hi [NUM_VEC];
  logic [31:0] data_w  [NUM_VEC];
  logic [31:0] ctrl_w  [NUM_VEC];

  logic [VEC_W-1:0] wr_vec, rd_vec;
  logic             wr_hit, rd_hit;

  assign wr_vec = wr_off[OFF_W-1:4];
  assign rd_vec = rd_off[OFF_W-1:4];
  assign wr_hit = wr_en && word_aligned(wr_off[1:0]) && (wr_vec < NV);
  assign rd_hit = word_aligned(rd_off[1:0]) && (rd_vec < NV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_VEC; i++) begin
        addr_lo[i] <= '0;
        addr_hi[i] <= '0;
        data_w[i]  <= '0;
        ctrl_w[i]  <= 32'h1;
      end
    end else if (wr_hit) begin
      case (field_of(wr_off[3:0]))
        FLD_ADDR_LO: addr_lo[wr_vec[IDX_W-1:0]] <= wr_data;
        FLD_ADDR_HI: addr_hi[wr_vec[IDX_W-1:0]] <= wr_data;
        FLD_DATA:    data_w[wr_vec[IDX_W-1:0]]  <= wr_data;
        default:     ctrl_w[wr_vec[IDX_W-1:0]]  <= wr_data;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_hit) begin
      case (field_of(rd_off[3:0]))
        FLD_ADDR_LO: rd_data = addr_lo[rd_vec[IDX_W-1:0]];
        FLD_ADDR_HI: rd_data = addr_hi[rd_vec[IDX_W-1:0]];
        FLD_DATA:    rd_data = data_w[rd_vec[IDX_W-1:0]];
        default:     rd_data = ctrl_w[rd_vec[IDX_W-1:0]];
      endcase
    end
  end

  assign fetch_msg.addr = {addr_hi[fetch_idx], addr_lo[fetch_idx]};
  assign fetch_msg.data = data_w[fetch_idx];

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_mask
    assign vec_mask[g] = ctrl_w[g][0];
  end

endmodule

// File: rtl/msix_pend.sv
module msix_pend #(
  parameter int NUM_VEC = 8,
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [IDX_W-1:0]   set_idx,
  input  logic               clr_en,
  input  logic [IDX_W-1:0]   clr_idx,
  input  logic               use_en,
  input  logic               use_up,
  input  logic [IDX_W-1:0]   use_idx,
  output logic [NUM_VEC-1:0] pend,
  output logic [NUM_VEC-1:0] in_use
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt [NUM_VEC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      for (int i = 0; i < NUM_VEC; i++) cnt[i] <= '0;
    end else begin
      if (set_en) pend[set_idx] <= 1'b1;
      if (clr_en) pend[clr_idx] <= 1'b0;
      if (use_en) begin
        if (use_up) begin
          if (cnt[use_idx] != CNT_MAX) cnt[use_idx] <= cnt[use_idx] + CNT_ONE;
        end else if (cnt[use_idx] != '0) begin
          cnt[use_idx] <= cnt[use_idx] - CNT_ONE;
          if (cnt[use_idx] == CNT_ONE) pend[use_idx] <= 1'b0;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_VEC; g++) begin : g_use
    assign in_use[g] = (cnt[g] != '0);
  end

endmodule

// File: rtl/msix_send.sv
module msix_send
  import msix_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_en,
  input  msg_t load_msg,
  input  logic msg_ready,
  output logic msg_valid,
  output msg_t msg_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_q     <= '0;
    end else if (load_en) begin
      msg_valid <= 1'b1;
      msg_q     <= load_msg;
    end else if (msg_valid && msg_ready) begin
      msg_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/msix_engine.sv
module msix_engine
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int CNT_W   = 2,
  localparam int IDX_W     = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int VEC_W     = IDX_W + 1,
  localparam int OFF_W     = VEC_W + 4,
  localparam int PBA_WORDS = ((NUM_VEC + 63) / 64) * 2,
  localparam int PBA_OFF_W = $clog2(PBA_WORDS) + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fn_mask,
  input  logic                 tbl_we,
  input  logic [OFF_W-1:0]     tbl_waddr,
  input  logic [31:0]          tbl_wdata,
  input  logic [OFF_W-1:0]     tbl_raddr,
  output logic [31:0]          tbl_rdata,
  input  logic [PBA_OFF_W-1:0] pba_raddr,
  output logic [31:0]          pba_rdata,
  input  logic                 use_en,
  input  logic                 use_up,
  input  logic [VEC_W-1:0]     use_vec,
  input  logic                 req_valid,
  input  logic [VEC_W-1:0]     req_vec,
  output logic                 req_ready,
  output logic                 msg_valid,
  input  logic                 msg_ready,
  output logic [63:0]          msg_addr,
  output logic [31:0]          msg_data
);

  localparam logic [VEC_W-1:0] NV = VEC_W'(NUM_VEC);
  localparam int PBA_BITS = PBA_WORDS * 32;

  logic [NUM_VEC-1:0] vec_mask, masked, pend_vec, in_use, replay_cand;
  logic [IDX_W-1:0]   req_idx, replay_idx, fetch_idx;
  logic               any_replay, req_take, req_live;
  logic               req_fire, req_park, req_drop, replay_fire, load_en;
  logic               use_hit;
  msg_t               fetch_msg, msg_q;
  logic [PBA_BITS-1:0] pba_flat;

  msix_table #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W), .VEC_W(VEC_W), .OFF_W(OFF_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_off(tbl_waddr), .wr_data(tbl_wdata),
    .rd_off(tbl_raddr), .rd_data(tbl_rdata),
    .fetch_idx(fetch_idx), .fetch_msg(fetch_msg), .vec_mask(vec_mask)
  );

  // Effective mask: per-vector bit or the function-wide one.
  assign masked = vec_mask | {NUM_VEC{fn_mask}};

  // Lowest-index pending vector that is now unmasked.
  assign replay_cand = pend_vec & ~masked;
  always_comb begin
    any_replay = 1'b0;
    replay_idx = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (replay_cand[i]) begin
        any_replay = 1'b1;
        replay_idx = IDX_W'(i);
      end
    end
  end

  // Host writes and replays win over new device requests.
  assign req_ready   = !msg_valid && !tbl_we && !any_replay;
  assign req_take    = req_valid && req_ready;
  assign req_idx     = req_vec[IDX_W-1:0];
  assign req_live    = (req_vec < NV) && in_use[req_idx];
  assign req_fire    = req_take && req_live && !masked[req_idx];
  assign req_park    = req_take && req_live && masked[req_idx];
  assign req_drop    = req_take && !req_live;
  assign replay_fire = !msg_valid && !tbl_we && any_replay;
  assign load_en     = req_fire || replay_fire;
  assign fetch_idx   = replay_fire ? replay_idx : req_idx;
  assign use_hit     = use_en && (use_vec < NV);

  msix_pend #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .set_en(req_park), .set_idx(req_idx),
    .clr_en(replay_fire), .clr_idx(replay_idx),
    .use_en(use_hit), .use_up(use_up), .use_idx(use_vec[IDX_W-1:0]),
    .pend(pend_vec), .in_use(in_use)
  );

  msix_send u_send (
    .clk(clk), .rst_n(rst_n),
    .load_en(load_en), .load_msg(fetch_msg),
    .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_q(msg_q)
  );

  assign msg_addr = msg_q.addr;
  assign msg_data = msg_q.data;

  // Pending array, bit v at flat position v, padding zero.
  always_comb begin
    pba_flat = '0;
    pba_flat[NUM_VEC-1:0] = pend_vec;
  end

  assign pba_rdata = word_aligned(pba_raddr[1:0])
                   ? pba_flat[pba_raddr[PBA_OFF_W-1:2] * 32 +: 32] : 32'h0;

endmodule

// File: rtl/msix_engine_chk.sv
module msix_engine_chk #(
  parameter int NUM_VEC = 8,
  parameter int IDX_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               msg_valid,
  input logic               msg_ready,
  input logic [63:0]        msg_addr,
  input logic [31:0]        msg_data,
  input logic               req_fire,
  input logic               req_park,
  input logic               replay_fire,
  input logic [IDX_W-1:0]   req_idx,
  input logic [IDX_W-1:0]   replay_idx,
  input logic [NUM_VEC-1:0] pend_vec,
  input logic [NUM_VEC-1:0] in_use
);

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data)); // R4

  AST_LOAD_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire || replay_fire) |=> msg_valid); // R4

  AST_PARK_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
    req_park |=> pend_vec[$past(req_idx)]); // R5

  AST_REPLAY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    replay_fire |=> !pend_vec[$past(replay_idx)]); // R7

  AST_PEND_IN_USE: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vec & ~in_use) == '0); // R8

  AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !(req_fire || replay_fire)); // R10

endmodule

bind msix_engine msix_engine_chk #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_addr(msg_addr), .msg_data(msg_data),
  .req_fire(req_fire), .req_park(req_park), .replay_fire(replay_fire),
  .req_idx(req_idx), .replay_idx(replay_idx),
  .pend_vec(pend_vec), .in_use(in_use)
);

// File: tb/msix_engine_tb.sv
module msix_engine_tb;

  localparam int OFF_W = 8;
  localparam int PBA_OFF_W = 3;
  localparam int VEC_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fn_mask = 1'b0;
  logic tbl_we = 1'b0;
  logic [OFF_W-1:0] tbl_waddr = '0;
  logic [31:0] tbl_wdata = '0;
  logic [OFF_W-1:0] tbl_raddr = '0;
  logic [31:0] tbl_rdata;
  logic [PBA_OFF_W-1:0] pba_raddr = '0;
  logic [31:0] pba_rdata;
  logic use_en = 1'b0, use_up = 1'b0;
  logic [VEC_W-1:0] use_vec = '0;
  logic req_valid = 1'b0;
  logic [VEC_W-1:0] req_vec = '0;
  logic req_ready, msg_valid;
  logic msg_ready = 1'b0;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  msix_engine u_dut (
    .clk(clk), .rst_n(rst_n), .fn_mask(fn_mask),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .tbl_raddr(tbl_raddr), .tbl_rdata(tbl_rdata),
    .pba_raddr(pba_raddr), .pba_rdata(pba_rdata),
    .use_en(use_en), .use_up(use_up), .use_vec(use_vec),
    .req_valid(req_valid), .req_vec(req_vec), .req_ready(req_ready),
    .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data)
  );

  function automatic logic [7:0] toff(input int v, input int f);
    return 8'(v * 16 + f * 4);
  endfunction

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] off, input logic [31:0] d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_waddr = off; tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic host_rd(input logic [7:0] off, output logic [31:0] d);
    tbl_raddr = off; #1; d = tbl_rdata;
  endtask

  task automatic pba_rd(input logic [2:0] off, output logic [31:0] d);
    pba_raddr = off; #1; d = pba_rdata;
  endtask

  task automatic use_op(input int v, input logic up);
    @(negedge clk);
    use_en = 1'b1; use_up = up; use_vec = VEC_W'(v);
    @(negedge clk);
    use_en = 1'b0;
  endtask

  task automatic send_req(input int v);
    @(negedge clk);
    req_valid = 1'b1; req_vec = VEC_W'(v);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic take_msg(input string req, input logic [63:0] ea, input logic [31:0] ed);
    check(req, "msg_valid", 64'(msg_valid), 64'd1);
    check(req, "msg_addr", msg_addr, ea);
    check(req, "msg_data", 64'(msg_data), 64'(ed));
    msg_ready = 1'b1;
    @(negedge clk);
    msg_ready = 1'b0;
    check(req, "msg_valid after accept", 64'(msg_valid), 64'd0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    host_rd(toff(0, 3), d); check("R1", "ctrl v0", 64'(d), 64'd1);
    host_rd(toff(7, 3), d); check("R1", "ctrl v7", 64'(d), 64'd1);
    host_rd(toff(3, 0), d); check("R1", "addr v3", 64'(d), 64'd0);
    host_rd(toff(3, 2), d); check("R1", "data v3", 64'(d), 64'd0);
    pba_rd(3'd0, d); check("R1", "pba w0", 64'(d), 64'd0);
    check("R1", "msg_valid", 64'(msg_valid), 64'd0);
    check("R1", "req_ready", 64'(req_ready), 64'd1);
  endtask

  task automatic t_table;
    logic [31:0] d;
    host_wr(toff(2, 0), 32'hFEE0_0020);
    host_wr(toff(2, 1), 32'h0000_0001);
    host_wr(toff(2, 2), 32'h0000_4122);
    host_rd(toff(2, 0), d); check("R2", "addr lo v2", 64'(d), 64'hFEE0_0020);
    host_rd(toff(2, 1), d); check("R2", "addr hi v2", 64'(d), 64'h1);
    host_rd(toff(2, 2), d); check("R2", "data v2", 64'(d), 64'h4122);
    host_wr(toff(2, 2) + 8'd1, 32'hDEAD_BEEF);
    host_rd(toff(2, 2), d); check("R3", "unaligned write ignored", 64'(d), 64'h4122);
    host_wr(8'h80, 32'h1234_5678);
    host_rd(8'h80, d); check("R3", "out-of-range read", 64'(d), 64'd0);
    host_rd(8'h00, d); check("R3", "no alias onto v0", 64'(d), 64'd0);
    host_rd(toff(2, 2) + 8'd2, d); check("R3", "unaligned read", 64'(d), 64'd0);
  endtask

  task automatic t_send;
    use_op(2, 1'b1);
    host_wr(toff(2, 3), 32'h0);
    send_req(2);
    check("R10", "req_ready while busy", 64'(req_ready), 64'd0);
    @(negedge clk); @(negedge clk);
    check("R4", "held valid", 64'(msg_valid), 64'd1);
    take_msg("R4", 64'h0000_0001_FEE0_0020, 32'h4122);
  endtask

  task automatic t_drop;
    logic [31:0] d;
    send_req(3);
    check("R6", "unused vector no msg", 64'(msg_valid), 64'd0);
    pba_rd(3'd0, d); check("R6", "unused vector no pend", 64'(d), 64'd0);
    send_req(9);
    check("R6", "out-of-range no msg", 64'(msg_valid), 64'd0);
    pba_rd(3'd0, d); check("R6", "out-of-range no pend", 64'(d), 64'd0);
  endtask

  task automatic t_mask_replay;
    logic [31:0] d;
    use_op(5, 1'b1);
    host_wr(toff(5, 0), 32'hFEE0_0050);
    host_wr(toff(5, 2), 32'h0000_0055);
    send_req(5);
    check("R5", "masked no msg", 64'(msg_valid), 64'd0);
    pba_rd(3'd0, d); check("R5", "pend bit5", 64'(d), 64'h20);
    host_wr(toff(5, 3), 32'h0);
    @(negedge clk);
    take_msg("R7", 64'hFEE0_0050, 32'h55);
    pba_rd(3'd0, d); check("R7", "pend cleared", 64'(d), 64'd0);
  endtask

  task automatic t_fn_mask;
    logic [31:0] d;
    @(negedge clk); fn_mask = 1'b1;
    send_req(5);
    send_req(2);
    check("R5", "fn_mask no msg", 64'(msg_valid), 64'd0);
    pba_rd(3'd0, d); check("R5", "pend 2 and 5", 64'(d), 64'h24);
    @(negedge clk); fn_mask = 1'b0;
    @(negedge clk);
    take_msg("R7", 64'h0000_0001_FEE0_0020, 32'h4122);
    @(negedge clk);
    take_msg("R7", 64'hFEE0_0050, 32'h55);
    pba_rd(3'd0, d); check("R7", "all replayed", 64'(d), 64'd0);
  endtask

  task automatic t_priority;
    logic [31:0] d;
    @(negedge clk);
    tbl_we = 1'b1; tbl_waddr = toff(2, 3); tbl_wdata = 32'h1;
    req_valid = 1'b1; req_vec = 4'd2;
    #1 check("R10", "req_ready during write", 64'(req_ready), 64'd0);
    @(negedge clk);
    tbl_we = 1'b0;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R10", "write masked first, no msg", 64'(msg_valid), 64'd0);
    pba_rd(3'd0, d); check("R10", "parked", 64'(d), 64'h04);
    host_wr(toff(2, 3), 32'h0);
    @(negedge clk);
    take_msg("R7", 64'h0000_0001_FEE0_0020, 32'h4122);
  endtask

  task automatic t_use;
    logic [31:0] d;
    use_op(6, 1'b1);
    use_op(6, 1'b1);
    send_req(6);
    pba_rd(3'd0, d); check("R8", "pend bit6", 64'(d), 64'h40);
    use_op(6, 1'b0);
    pba_rd(3'd0, d); check("R8", "still pending at count 1", 64'(d), 64'h40);
    use_op(6, 1'b0);
    pba_rd(3'd0, d); check("R8", "cleared at count 0", 64'(d), 64'd0);
    use_op(6, 1'b0);
    send_req(6);
    pba_rd(3'd0, d); check("R8", "unuse at zero ignored", 64'(d), 64'd0);
    check("R8", "no msg", 64'(msg_valid), 64'd0);
  endtask

  task automatic t_pba;
    logic [31:0] d;
    use_op(0, 1'b1);
    use_op(7, 1'b1);
    send_req(7);
    send_req(0);
    pba_rd(3'd0, d); check("R9", "word0 bits 0 and 7", 64'(d), 64'h81);
    pba_rd(3'd4, d); check("R9", "padding word", 64'(d), 64'd0);
    pba_rd(3'd1, d); check("R9", "unaligned read", 64'(d), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_table();
    t_send();
    t_drop();
    t_mask_replay();
    t_fn_mask();
    t_priority();
    t_use();
    t_pba();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule